// File: doc/BRIEF.md
# Prescaled Dual Interval Timer

This block holds one shared prescaler and a set of independent up-counters (two by default) behind a simple 32-bit register bus. The prescaler runs freely and emits a single-cycle tick whenever its running count has reached a programmed limit, then starts over from zero. Each counter picks its own advance strobe: either every clock cycle or only the prescaler tick.

A counter climbs to its own programmed limit. When it is at that limit and its strobe arrives, an overflow occurs. The counter then either restarts at zero or stays parked at the limit, depending on a mode bit. Every overflow produces a one-cycle pulse on a dedicated output. Software can read the count at any time and can also overwrite it.

The bus is a single-cycle write port with a combinational read. Reads are decoded from the same address as writes. All registers are word-aligned.

Top module: `presc_timer`

## Requirements
- R1: While reset is high every register reads 0 and every overflow output is low. Reset is synchronous and active high.
- R2: The prescaler count rises by one per clock. When the count is greater than or equal to the prescaler limit, a tick is issued in that cycle and the count returns to 0. The tick period is therefore limit+1 clocks, and a limit of 0 ticks on every clock. A counter with control bit 0 set advances only on these ticks.
- R3: A counter with control bit 0 clear advances on every clock.
- R4: When a counter's value is greater than or equal to its limit and its strobe is active, and control bit 16 is 0, the value becomes 0 on that edge.
- R5: Under the same overflow condition with control bit 16 set to 1, the value becomes equal to the limit.
- R6: Each overflow drives that counter's output bit high for exactly the one cycle after the overflow edge. The output is low in every other cycle.
- R7: A write to a counter's value register loads the written data on that edge. It overrides counting and overflow in the same cycle, and it produces no overflow pulse for that cycle.
- R8: The register map is as follows. Byte address 0x00 holds the prescaler limit. Counter k (k = 0, 1, ...) has its control register at 0x10*(k+1), its limit at +0x4 and its value at +0x8. In the control register, bit 0 selects the strobe source and bit 16 selects the overflow mode; all other control bits read 0. Any other address reads 0, and a write to it changes nothing.
- R9: A write to a control register or a limit register takes effect from the following clock. Counting in the cycle of the write still uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Byte address for read and write |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| ovf_pulse | output | NUM_TIMERS (2) | One-cycle overflow pulse per counter |

## Verification
Two events can land on the same edge: a software write to a counter's value (or to its limit or control) and that counter's overflow on its strobe. The directed phase parks a counter at its limit and writes its value register on exactly that edge. In that case the written data must win and no pulse may appear. It also rewrites a limit on an overflow edge, where the old limit must decide the outcome. The random phase then mixes writes at up to 25% of cycles with small limits, so that these collisions recur under both strobe sources and both overflow modes. Each cycle the count and the pulse are compared against a bench model.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int BUS_W    = 32;
    localparam int SRC_BIT  = 0;
    localparam int MODE_BIT = 16;

    localparam logic [3:0] OFS_CTRL  = 4'h0;
    localparam logic [3:0] OFS_LIMIT = 4'h4;
    localparam logic [3:0] OFS_VALUE = 4'h8;

    typedef struct packed {
        logic hold_at_limit;
        logic use_prescale;
    } ctrl_t;

    typedef enum logic [1:0] {
        RK_CTRL,
        RK_LIMIT,
        RK_VALUE,
        RK_NONE
    } rkind_t;

    function automatic rkind_t decode_ofs(input logic [3:0] ofs);
        case (ofs)
            OFS_CTRL:  return RK_CTRL;
            OFS_LIMIT: return RK_LIMIT;
            OFS_VALUE: return RK_VALUE;
            default:   return RK_NONE;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [BUS_W-1:0] w;
        w           = '0;
        w[SRC_BIT]  = c.use_prescale;
        w[MODE_BIT] = c.hold_at_limit;
        return w;
    endfunction

endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lim_we,
    input  logic [CNT_W-1:0] lim_wdata,
    output logic [CNT_W-1:0] lim_q,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q >= lim_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
            if (lim_we)
                lim_q <= lim_wdata;
        end
    end

    // R2: a tick restarts the prescaler count
    a_r2_tick_restart: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_q == '0));

    // R2: without a tick the count steps by one
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        !tick |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R2: a zero limit ticks on every clock
    a_r2_zero_limit: assert property (@(posedge clk) disable iff (rst)
        (lim_q == '0) |-> tick);

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter
    import ptmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic             lim_we,
    input  logic             val_we,
    input  logic [BUS_W-1:0] wdata,
    input  logic             pre_tick,
    output ctrl_t            ctrl_q,
    output logic [CNT_W-1:0] lim_q,
    output logic [CNT_W-1:0] val_q,
    output logic             ovf_q
);

    logic             step;
    logic             at_lim;
    logic             wrap;
    logic [CNT_W-1:0] val_d;

    assign step   = ctrl_q.use_prescale ? pre_tick : 1'b1;
    assign at_lim = (val_q >= lim_q);
    assign wrap   = step && at_lim && !val_we;

    always_comb begin
        if (val_we)
            val_d = wdata[CNT_W-1:0];
        else if (wrap)
            val_d = ctrl_q.hold_at_limit ? lim_q : '0;
        else if (step)
            val_d = val_q + 1'b1;
        else
            val_d = val_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            lim_q  <= '0;
            val_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            val_q <= val_d;
            ovf_q <= wrap;
            if (ctrl_we) begin
                ctrl_q.use_prescale  <= wdata[SRC_BIT];
                ctrl_q.hold_at_limit <= wdata[MODE_BIT];
            end
            if (lim_we)
                lim_q <= wdata[CNT_W-1:0];
        end
    end

    // R7: a value write loads the data and suppresses the pulse
    a_r7_value_load: assert property (@(posedge clk) disable iff (rst)
        val_we |=> (val_q == $past(wdata[CNT_W-1:0])) && !ovf_q);

    // R4: overflow in clear mode returns to zero
    a_r4_clear_on_wrap: assert property (@(posedge clk) disable iff (rst)
        (!val_we && step && at_lim && !ctrl_q.hold_at_limit) |=> (val_q == '0));

    // R5: overflow in hold mode parks at the old limit
    a_r5_hold_on_wrap: assert property (@(posedge clk) disable iff (rst)
        (!val_we && step && at_lim && ctrl_q.hold_at_limit) |=> (val_q == $past(lim_q)));

    // R6: every overflow yields a pulse in the next cycle
    a_r6_pulse_follows: assert property (@(posedge clk) disable iff (rst)
        (!val_we && step && at_lim) |=> ovf_q);

    // R6: no pulse without an overflow in the cycle before
    a_r6_pulse_only_on_wrap: assert property (@(posedge clk) disable iff (rst)
        !(step && at_lim) |=> !ovf_q);

    // R2: in prescale mode the value is frozen between ticks
    a_r2_frozen_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.use_prescale && !pre_tick && !val_we) |=> $stable(val_q));

endmodule

// File: rtl/ptmr_rdmux.sv
module ptmr_rdmux
    import ptmr_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int NUM_TIMERS = 2,
    parameter int ADDR_W     = 8
) (
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [CNT_W-1:0]                   plim,
    input  ctrl_t [NUM_TIMERS-1:0]             ctrl_all,
    input  logic [NUM_TIMERS-1:0][CNT_W-1:0]   lim_all,
    input  logic [NUM_TIMERS-1:0][CNT_W-1:0]   val_all,
    output logic [BUS_W-1:0]                   rdata
);

    localparam int SLOT_W = ADDR_W - 4;

    logic [SLOT_W-1:0] slot;
    logic [3:0]        ofs;

    assign slot = addr[ADDR_W-1:4];
    assign ofs  = addr[3:0];

    always_comb begin
        rdata = '0;
        if (addr == '0)
            rdata = BUS_W'(plim);
        for (int k = 0; k < NUM_TIMERS; k++) begin
            if (slot == SLOT_W'(k + 1)) begin
                case (decode_ofs(ofs))
                    RK_CTRL:  rdata = ctrl_to_word(ctrl_all[k]);
                    RK_LIMIT: rdata = BUS_W'(lim_all[k]);
                    RK_VALUE: rdata = BUS_W'(val_all[k]);
                    default:  rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/presc_timer.sv
module presc_timer
    import ptmr_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int NUM_TIMERS = 2,
    parameter int ADDR_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [BUS_W-1:0]      bus_wdata,
    output logic [BUS_W-1:0]      bus_rdata,
    output logic [NUM_TIMERS-1:0] ovf_pulse
);

    localparam int SLOT_W = ADDR_W - 4;

    logic                               pre_tick;
    logic [CNT_W-1:0]                   plim;
    ctrl_t [NUM_TIMERS-1:0]             ctrl_all;
    logic [NUM_TIMERS-1:0][CNT_W-1:0]   lim_all;
    logic [NUM_TIMERS-1:0][CNT_W-1:0]   val_all;
    rkind_t                             wr_kind;

    assign wr_kind = decode_ofs(bus_addr[3:0]);

    ptmr_prescaler #(.CNT_W(CNT_W)) u_presc (
        .clk       (clk),
        .rst       (rst),
        .lim_we    (bus_we && (bus_addr == '0)),
        .lim_wdata (bus_wdata[CNT_W-1:0]),
        .lim_q     (plim),
        .tick      (pre_tick)
    );

    for (genvar k = 0; k < NUM_TIMERS; k++) begin : g_tmr
        logic sel;
        assign sel = bus_we && (bus_addr[ADDR_W-1:4] == SLOT_W'(k + 1));

        ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .ctrl_we  (sel && (wr_kind == RK_CTRL)),
            .lim_we   (sel && (wr_kind == RK_LIMIT)),
            .val_we   (sel && (wr_kind == RK_VALUE)),
            .wdata    (bus_wdata),
            .pre_tick (pre_tick),
            .ctrl_q   (ctrl_all[k]),
            .lim_q    (lim_all[k]),
            .val_q    (val_all[k]),
            .ovf_q    (ovf_pulse[k])
        );
    end

    ptmr_rdmux #(
        .CNT_W      (CNT_W),
        .NUM_TIMERS (NUM_TIMERS),
        .ADDR_W     (ADDR_W)
    ) u_rd (
        .addr     (bus_addr),
        .plim     (plim),
        .ctrl_all (ctrl_all),
        .lim_all  (lim_all),
        .val_all  (val_all),
        .rdata    (bus_rdata)
    );

    // R1: outputs are quiet in the cycle after a reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (ovf_pulse == '0));

endmodule

// File: tb/presc_timer_tb.sv
`timescale 1ns/100ps
module presc_timer_tb;

    localparam int NT = 2;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          we;
    logic [31:0]   wdata;
    logic [31:0]   rdata;
    logic [NT-1:0] ovf;

    always #4 clk = ~clk;

    presc_timer #(.CNT_W(32), .NUM_TIMERS(NT), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .ovf_pulse(ovf)
    );

    logic [31:0] m_plim, m_pcnt;
    logic        m_src [NT];
    logic        m_hold[NT];
    logic [31:0] m_lim [NT];
    logic [31:0] m_val [NT];
    logic        m_ovf [NT];
    string       m_tag [NT];

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [7:0] addr_pool [12] = '{8'h00, 8'h04, 8'h0C, 8'h10, 8'h14, 8'h18,
                                   8'h1C, 8'h20, 8'h24, 8'h28, 8'h30, 8'h2C};

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
        if (a == 8'h00) return m_plim;
        for (int k = 0; k < NT; k++) begin
            if (a == AW'((k + 1) * 16))     return {15'd0, m_hold[k], 15'd0, m_src[k]};
            if (a == AW'((k + 1) * 16 + 4)) return m_lim[k];
            if (a == AW'((k + 1) * 16 + 8)) return m_val[k];
        end
        return 32'd0;
    endfunction

    task automatic model_reset();
        m_plim = 0; m_pcnt = 0;
        for (int k = 0; k < NT; k++) begin
            m_src[k] = 0; m_hold[k] = 0; m_lim[k] = 0; m_val[k] = 0; m_ovf[k] = 0;
            m_tag[k] = "R3";
        end
    endtask

    task automatic model_step(input logic w, input logic [AW-1:0] a, input logic [31:0] d);
        logic ptick;
        ptick = (m_pcnt >= m_plim);
        for (int k = 0; k < NT; k++) begin
            logic st, wv, wc, wl;
            logic [AW-1:0] base;
            base = AW'((k + 1) * 16);
            st = m_src[k] ? ptick : 1'b1;
            wv = w && (a == base + 8'd8);
            wc = w && (a == base);
            wl = w && (a == base + 8'd4);
            m_tag[k] = m_src[k] ? "R2" : "R3";
            m_ovf[k] = 1'b0;
            if (wv) begin
                m_val[k] = d;
                m_tag[k] = "R7";
            end else if (st && (m_val[k] >= m_lim[k])) begin
                m_ovf[k] = 1'b1;
                m_tag[k] = m_hold[k] ? "R5" : "R4";
                m_val[k] = m_hold[k] ? m_lim[k] : 32'd0;
            end else if (st) begin
                m_val[k] = m_val[k] + 1;
            end
            if ((wc || wl) && !wv) m_tag[k] = "R9";
            if (wc) begin m_src[k] = d[0]; m_hold[k] = d[16]; end
            if (wl) m_lim[k] = d;
        end
        m_pcnt = ptick ? 32'd0 : m_pcnt + 1;
        if (w && a == 8'h00) m_plim = d;
    endtask

    task automatic cyc(input logic w, input logic [AW-1:0] a, input logic [31:0] d);
        logic [AW-1:0] ra;
        addr = a; we = w; wdata = d;
        model_step(w, a, d);
        @(posedge clk);
        #1;
        we = 1'b0;
        for (int k = 0; k < NT; k++) begin
            chk("R6", $sformatf("ovf[%0d]", k), {31'd0, ovf[k]}, {31'd0, m_ovf[k]});
            addr = AW'((k + 1) * 16 + 8);
            #0.5;
            chk(m_tag[k], $sformatf("value[%0d]", k), rdata, m_val[k]);
        end
        ra = addr_pool[$urandom_range(0, 11)];
        addr = ra;
        #0.5;
        chk("R8", $sformatf("read@%h", ra), rdata, exp_read(ra));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; we = 1'b0; addr = '0; wdata = '0;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state at every address and on the pulse outputs
        for (int i = 0; i < 12; i++) begin
            addr = addr_pool[i];
            #0.2;
            chk("R1", $sformatf("reset read@%h", addr_pool[i]), rdata, 32'd0);
        end
        chk("R1", "reset ovf", {30'd0, ovf}, 32'd0);
        rst = 1'b0;

        // R3/R4: defaults count every clock, limit 0 wraps each cycle
        idle(3);

        // R2: prescaler limit 0 with timer 0 in prescale mode
        cyc(1'b1, 8'h10, 32'h0000_0001);
        cyc(1'b1, 8'h14, 32'd3);
        cyc(1'b1, 8'h18, 32'd0);
        idle(10);

        // R2/R5: prescaler limit 2, timer 1 prescaled, hold mode, limit 2
        cyc(1'b1, 8'h00, 32'd2);
        cyc(1'b1, 8'h20, 32'h0001_0001);
        cyc(1'b1, 8'h24, 32'd2);
        cyc(1'b1, 8'h28, 32'd0);
        idle(14);

        // R7: value write on the overflow edge of timer 0
        cyc(1'b1, 8'h10, 32'h0000_0000);
        cyc(1'b1, 8'h14, 32'd2);
        cyc(1'b1, 8'h18, 32'd0);
        idle(2);
        cyc(1'b1, 8'h18, 32'd5);
        idle(3);

        // R9: limit rewrite on an overflow edge uses the old limit
        cyc(1'b1, 8'h18, 32'd1);
        cyc(1'b1, 8'h14, 32'd9);
        idle(3);
        cyc(1'b1, 8'h10, 32'h0001_0000);
        cyc(1'b1, 8'h18, 32'd9);
        cyc(1'b1, 8'h14, 32'd4);
        idle(3);

        // R8: writes to unmapped addresses are ignored
        cyc(1'b1, 8'h0C, 32'hFFFF_FFFF);
        cyc(1'b1, 8'h30, 32'hFFFF_FFFF);
        cyc(1'b1, 8'h1C, 32'hFFFF_FFFF);
        idle(2);

        // Random mix
        for (int i = 0; i < 2000; i++) begin
            if ($urandom_range(0, 3) == 0) begin
                logic [AW-1:0] a;
                logic [31:0] d;
                a = addr_pool[$urandom_range(0, 11)];
                case (a[3:0])
                    4'h0: d = (a == 8'h00) ? 32'($urandom_range(0, 3)) : $urandom;
                    4'h4: d = 32'($urandom_range(0, 6));
                    4'h8: d = ($urandom_range(0, 9) == 0) ? 32'hFFFF_FFF0
                                                          : 32'($urandom_range(0, 8));
                    default: d = $urandom;
                endcase
                cyc(1'b1, a, d);
            end else begin
                cyc(1'b0, 8'h00, 32'd0);
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule